// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits at the back of a shader core's front end. A fixed pool of resident warps share it. Each warp is a group of 32 threads that run one instruction stream. In every cycle the block chooses at most one warp and issues that warp's pending instruction to one of three execution resources: the arithmetic lanes, the memory (load/store) ports or the special-function units. The choice is made in the same cycle that the inputs are presented. The scheduler state moves forward on the following rising clock edge.

A warp can be chosen only when three conditions hold. Its ready input must be high. It must not still be waiting after its last issue. Its target resource must be free. A resource narrower than 32 lanes takes several cycles to process one warp instruction, and during those cycles it is busy. When a warp issues, the block marks it as waiting. The warp stays waiting until its stall-clear input is pulsed. Stalled warps are skipped, so that other warps hide their latency. The candidates are scanned in round-robin order, starting just after the warp that issued last.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and after it is released, `issue_valid_o` is 0. Every warp starts in the waiting state, so no warp issues until its `stall_clr_i` bit has been pulsed.
- R2: A warp is issued only in a cycle in which its `warp_ready_i` bit is 1. A warp whose ready bit is 0 is never issued, whatever its other state.
- R3: At most one warp issues per cycle. `issue_wid_o` gives the index of the chosen warp, from 0 to 47.
- R4: The eligible warps are scanned starting at the index one above the warp that issued last, wrapping from 47 to 0. After reset the scan starts at warp 0.
- R5: Op code 3 (special function) occupies the special-function units for 8 cycles. A special-function instruction that issues in cycle t blocks the next one until cycle t+8.
- R6: Op codes 1 (double-precision arithmetic) and 2 (load/store) each occupy their resource for 2 cycles. Code 1 occupies the arithmetic lanes and code 2 occupies the memory ports. Either of them blocks its resource in cycle t+1.
- R7: Op code 0 (single-precision or integer arithmetic) occupies the arithmetic lanes for one cycle only. Such warps can therefore issue back to back, one in each cycle.
- R8: A warp whose resource is busy is skipped in that cycle. A later warp in round-robin order whose resource is free issues in its place.
- R9: A warp that issues enters the waiting state on the next edge. A pulse on its `stall_clr_i` bit makes it eligible again from the following cycle.
- R10: `issue_op_o` gives the 2-bit op code of the issued warp. The codes are 0 int/single, 1 double, 2 load/store and 3 special function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready_i | input | 48 | One bit per warp: the warp has an instruction and no outstanding hazard |
| warp_op_i | input | 96 | 2-bit op code per warp. Warp w uses bits [2w+1:2w] |
| stall_clr_i | input | 48 | One bit per warp: pulse to release the warp from the waiting state |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_wid_o | output | 6 | Index of the issuing warp |
| issue_op_o | output | 2 | Op code of the issuing warp |

## Verification
The hardest case to reach is a collision between the busy window of a resource and round-robin order. This means a warp that is next in line for a busy unit must be passed over, while a later warp with a different op code issues. The stimulus enables only a small, hand-picked set of ready warps for each phase. Two of them share a slow resource and one uses a different resource. This makes the exact cycle in which the busy counter frees the resource visible as the point where the skipped warp finally issues. The same method is used to show that an 8-cycle special-function occupancy, and a double-precision instruction, each block the resource that they hold.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_CLS   = 3;
  localparam int CLS_ARITH = 0;
  localparam int CLS_MEM   = 1;
  localparam int CLS_SFU   = 2;

  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_DP  = 2'd1,
    OP_MEM = 2'd2,
    OP_SFU = 2'd3
  } op_e;

  function automatic logic [1:0] op_to_cls(input logic [1:0] op);
    case (op)
      OP_MEM:  return 2'(CLS_MEM);
      OP_SFU:  return 2'(CLS_SFU);
      default: return 2'(CLS_ARITH);
    endcase
  endfunction
endpackage

// File: rtl/sched_rr_arb.sv
module sched_rr_arb #(
  parameter int N = 48,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] last_i,
  output logic         gnt_valid_o,
  output logic [W-1:0] gnt_idx_o,
  output logic [N-1:0] gnt_oh_o
);
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int off = 1; off <= N; off++) begin
      int j;
      j = int'(last_i) + off;
      if (j >= N) j = j - N;
      if (!gnt_valid_o && req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = W'(j);
      end
    end
  end

  always_comb begin
    gnt_oh_o = '0;
    if (gnt_valid_o) gnt_oh_o[gnt_idx_o] = 1'b1;
  end

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh_o));

  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> req_i[gnt_idx_o]);
endmodule

// File: rtl/sched_unit_busy.sv
module sched_unit_busy #(
  parameter int NCLS  = sched_pkg::NUM_CLS,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [1:0]       take_cls_i,
  input  logic [CNT_W-1:0] take_hold_m1_i,
  output logic [NCLS-1:0]  free_o
);
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit;

    assign hit = take_i && (take_cls_i == 2'(c));

    always_comb begin
      cnt_d = cnt_q;
      if (hit)              cnt_d = take_hold_m1_i;
      else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign free_o[c] = (cnt_q == '0);

    // R8
    busy_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && cnt_q != '0));
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS   = 48,
  parameter int THREADS     = 32,
  parameter int ARITH_LANES = 32,
  parameter int DP_LANES    = 16,
  parameter int MEM_LANES   = 16,
  parameter int SFU_LANES   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WARPS-1:0]             warp_ready_i,
  input  logic [2*NUM_WARPS-1:0]           warp_op_i,
  input  logic [NUM_WARPS-1:0]             stall_clr_i,
  output logic                             issue_valid_o,
  output logic [$clog2(NUM_WARPS)-1:0]     issue_wid_o,
  output logic [1:0]                       issue_op_o
);
  import sched_pkg::*;

  localparam int WID_W    = $clog2(NUM_WARPS);
  localparam int HOLD_INT = THREADS / ARITH_LANES;
  localparam int HOLD_DP  = THREADS / DP_LANES;
  localparam int HOLD_MEM = THREADS / MEM_LANES;
  localparam int HOLD_SFU = THREADS / SFU_LANES;
  localparam int CNT_W    = $clog2(HOLD_SFU + 1);

  logic [NUM_WARPS-1:0] stalled_q, stalled_d;
  logic [WID_W-1:0]     last_q, last_d;
  logic                 last_en;
  logic [NUM_CLS-1:0]   cls_free;
  logic [NUM_WARPS-1:0] eligible;
  logic [NUM_WARPS-1:0] gnt_oh;
  logic                 gnt_valid;
  logic [WID_W-1:0]     gnt_idx;
  logic [1:0]           win_op;
  logic [CNT_W-1:0]     hold_m1;

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      eligible[w] = warp_ready_i[w] && !stalled_q[w]
                    && cls_free[op_to_cls(warp_op_i[2*w +: 2])];
    end
  end

  sched_rr_arb #(.N(NUM_WARPS), .W(WID_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (eligible),
    .last_i     (last_q),
    .gnt_valid_o(gnt_valid),
    .gnt_idx_o  (gnt_idx),
    .gnt_oh_o   (gnt_oh)
  );

  assign win_op = warp_op_i[2*gnt_idx +: 2];

  always_comb begin
    case (win_op)
      OP_DP:   hold_m1 = CNT_W'(HOLD_DP - 1);
      OP_MEM:  hold_m1 = CNT_W'(HOLD_MEM - 1);
      OP_SFU:  hold_m1 = CNT_W'(HOLD_SFU - 1);
      default: hold_m1 = CNT_W'(HOLD_INT - 1);
    endcase
  end

  sched_unit_busy #(.NCLS(NUM_CLS), .CNT_W(CNT_W)) u_busy (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_i        (gnt_valid),
    .take_cls_i    (op_to_cls(win_op)),
    .take_hold_m1_i(hold_m1),
    .free_o        (cls_free)
  );

  // next state: an issue re-stalls its warp even if a clear arrives together
  always_comb begin
    stalled_d = (stalled_q & ~stall_clr_i) | gnt_oh;
    last_en   = gnt_valid;
    last_d    = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stalled_q <= '1;
      last_q    <= WID_W'(NUM_WARPS - 1);
    end else begin
      stalled_q <= stalled_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign issue_valid_o = gnt_valid;
  assign issue_wid_o   = gnt_idx;
  assign issue_op_o    = win_op;

  // R9
  issued_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |=> stalled_q[$past(issue_wid_o)]);

  // R2
  ready_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> warp_ready_i[issue_wid_o]);

  // R3
  wid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (int'(issue_wid_o) < NUM_WARPS));
endmodule

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
  localparam int N = 48;

  typedef struct {
    logic       v;
    logic [5:0] w;
    logic [1:0] op;
    string      req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  rdy;
  logic [2*N-1:0] ops;
  logic [N-1:0]  clr;
  logic          iv;
  logic [5:0]    iw;
  logic [1:0]    iop;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  warp_issue_sched u0 (
    .clk(clk), .rst_n(rst_n), .warp_ready_i(rdy), .warp_op_i(ops),
    .stall_clr_i(clr), .issue_valid_o(iv), .issue_wid_o(iw), .issue_op_o(iop)
  );

  function automatic logic [N-1:0] bits(input int a, input int b, input int c);
    logic [N-1:0] m = '0;
    if (a >= 0) m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    if (c >= 0) m[c] = 1'b1;
    return m;
  endfunction

  // driver: apply one cycle of stimulus and queue what must appear
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] c,
                      input logic v, input int w, input int op, input string req);
    exp_t e;
    @(negedge clk);
    rdy = r; clr = c;
    e.v = v; e.w = 6'(w); e.op = 2'(op); e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per cycle, samples mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (iv !== e.v || (e.v && (iw !== e.w || iop !== e.op))) begin
          fails++;
          $display("FAIL %s: got v=%0b w=%0d op=%0d, expected v=%0b w=%0d op=%0d",
                   e.req, iv, iw, iop, e.v, e.w, e.op);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rdy = '1; ops = '0; clr = '0;
    #12;
    checks++;
    if (iv !== 1'b0) begin
      fails++;
      $display("FAIL R1: got issue_valid=%0b in reset, expected 0", iv);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: all warps still waiting after reset
    step('1, '0, 0, 0, 0, "R1");
    step('1, '0, 0, 0, 0, "R1");
    // release all warps; clear takes effect next cycle (R9)
    step('1, '1, 0, 0, 0, "R9");
    // R4 scan starts at 0, R7 int ops back to back
    step('1, '0, 1, 0, 0, "R4");
    step('1, '0, 1, 1, 0, "R7");
    step('1, '0, 1, 2, 0, "R7");
    // R2: only ready warps 5 and 10
    step(bits(5, 10, -1), '0, 1, 5, 0, "R2");
    step(bits(5, 10, -1), '0, 1, 10, 0, "R2");
    step(bits(5, 10, -1), '0, 0, 0, 0, "R9");
    step(bits(5, 10, -1), bits(5, -1, -1), 0, 0, 0, "R9");
    step(bits(5, 10, -1), '0, 1, 5, 0, "R4");

    // R5: special-function occupancy of 8 cycles
    ops[40 +: 2] = 2'd3; ops[42 +: 2] = 2'd3; ops[44 +: 2] = 2'd0;
    step(bits(20, 21, 22), '0, 1, 20, 3, "R10");
    step(bits(20, 21, 22), '0, 1, 22, 0, "R8");
    for (int k = 0; k < 6; k++) step(bits(20, 21, 22), '0, 0, 0, 0, "R5");
    step(bits(20, 21, 22), '0, 1, 21, 3, "R5");

    // R6: load/store occupancy of 2 cycles
    ops[60 +: 2] = 2'd2; ops[62 +: 2] = 2'd2;
    step(bits(30, 31, -1), '0, 1, 30, 2, "R6");
    step(bits(30, 31, -1), '0, 0, 0, 0, "R6");
    step(bits(30, 31, -1), '0, 1, 31, 2, "R6");

    // R6: double precision holds arithmetic lanes, blocking an int op too
    ops[84 +: 2] = 2'd1; ops[86 +: 2] = 2'd0;
    step(bits(42, 43, -1), '0, 1, 42, 1, "R6");
    step(bits(42, 43, -1), '0, 0, 0, 0, "R6");
    step(bits(42, 43, -1), '0, 1, 43, 0, "R6");

    // R8: busy memory skipped, int warp issues instead, then wrap
    ops[88 +: 2] = 2'd2; ops[90 +: 2] = 2'd2; ops[92 +: 2] = 2'd0;
    step(bits(44, 45, 46), '0, 1, 44, 2, "R8");
    step(bits(44, 45, 46), '0, 1, 46, 0, "R8");
    step(bits(44, 45, 46), '0, 1, 45, 2, "R8");

    // R1: reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step('1, '0, 0, 0, 0, "R1");
    step('1, bits(7, -1, -1), 0, 0, 0, "R1");
    step('1, '0, 1, 7, 0, "R1");

    step('0, '0, 0, 0, 0, "R2");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule